// File: doc/BRIEF.md
# Automatic Bit-Clock Source Selector and Generator

This block supplies the bit clock for a serial audio receiver. It watches an optional bit clock that arrives from outside. When that clock runs fast enough, the block passes it through. When it is missing, the block makes its own bit clock from the master clock. The generated clock is phase-locked to the frame (left/right) clock. All inputs are sampled on the master clock `clk`, and every output is registered on that clock.

The switch between the two sources happens without any software. The block goes to external mode after enough external bit-clock rising edges fall inside one half of a frame. It goes back to internal mode once the external clock has been silent for two whole frame periods.

In internal mode the divide factor depends on two inputs: the master-to-frame clock ratio code and the serial format select. The divide factor in use is always visible on `div_o`. The block carries no data stream, so every pin is a plain control or clock-qualifier signal with no handshake.

Top module: `bitclk_autosel`

## Requirements
- R1: In internal mode the bit clock `bclk_o` has period `div_o` master cycles and a 50 % duty cycle. It is low for the first `div_o/2` cycles of each period and high for the rest. `bclk_rise_o` pulses for one cycle on exactly the cycles where `bclk_o` goes from low to high. Each frame period therefore holds (frame length / `div_o`) rising pulses.
- R2: Every transition of `lrck_i`, rising or falling, restarts the internal divider. The internal `bclk_o` is low for the first `div_o/2` cycles after the transition is registered.
- R3: The master ratio codes on `ratio_i` are 0=128, 1=192, 2=256, 3=384 and 4=512. Codes 5 to 7 are treated as 256. The format codes on `fmt_i` are 0=I2S, 1=left-justified, 2=right-justified 24-bit and 3=right-justified 16-bit. With ratio 192 or 384 the internal bit clock is 48 times the frame rate. Otherwise it is 32 times the frame rate for formats 0 and 3, and 64 times for formats 1 and 2.
- R4: `div_o` equals the master ratio divided by the bit-clock ratio. It is therefore always 2, 4, 8 or 16.
- R5: The block enters external mode (`ext_mode_o`=1) when the 16th rising edge of `sclk_ext_i` is registered within a single level phase of `lrck_i`. The edge count restarts at every `lrck_i` transition.
- R6: 15 external rising edges in each phase, repeated frame after frame, never select external mode.
- R7: External mode is left on the third `lrck_i` rising edge registered after the last external rising edge, that is, after two whole silent frame periods. Mode is not left any earlier.
- R8: In external mode `bclk_o` follows `sclk_ext_i` one cycle later. `bclk_rise_o` marks each registered rising edge of `sclk_ext_i`.
- R9: During and right after reset, `bclk_o`, `bclk_rise_o` and `ext_mode_o` are 0, and the block is in internal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rst_n | input | 1 | asynchronous reset, active low |
| lrck_i | input | 1 | frame clock, synchronous to clk |
| sclk_ext_i | input | 1 | external bit clock, sampled on clk |
| fmt_i | input | 2 | serial format select (R3) |
| ratio_i | input | 3 | master-to-frame ratio code (R3) |
| bclk_o | output | 1 | selected bit clock level |
| bclk_rise_o | output | 1 | one-cycle pulse at each bit-clock rising edge |
| ext_mode_o | output | 1 | 1 = external bit clock selected |
| div_o | output | 5 | internal divide factor in use |

## Verification
The bench drives burst patterns of exactly 15 and exactly 16 external edges per frame phase. An off-by-one edge threshold would flip the mode on the wrong one of those two patterns. It stops the external clock and watches the frame rising edges one by one, so a silence timer that counted phases instead of whole periods would drop to internal mode a frame too early. A frame half-period that is not a multiple of the divide factor exposes a divider that fails to restart on both frame edges. A sweep of every ratio and format code catches a wrong divide-factor entry, including the fallback for the unused ratio codes.

// File: rtl/bitclk_autosel_pkg.sv
package bitclk_autosel_pkg;

  typedef enum logic [2:0] {
    RC_128 = 3'd0,
    RC_192 = 3'd1,
    RC_256 = 3'd2,
    RC_384 = 3'd3,
    RC_512 = 3'd4
  } ratio_code_e;

  typedef enum logic [1:0] {
    FMT_I2S  = 2'd0,
    FMT_LJ   = 2'd1,
    FMT_RJ24 = 2'd2,
    FMT_RJ16 = 2'd3
  } fmt_code_e;

  function automatic int unsigned master_ratio(input logic [2:0] code);
    case (code)
      3'd0:    return 128;
      3'd1:    return 192;
      3'd3:    return 384;
      3'd4:    return 512;
      default: return 256;
    endcase
  endfunction

  function automatic int unsigned bit_ratio(input int unsigned mr, input logic [1:0] fmt);
    if (mr == 192 || mr == 384) return 48;
    if (fmt == FMT_I2S || fmt == FMT_RJ16) return 32;
    return 64;
  endfunction

endpackage

// File: rtl/bclk_ratio_sel.sv
module bclk_ratio_sel
  import bitclk_autosel_pkg::*;
#(
  parameter int DIV_W = 5
) (
  input  logic [1:0]       fmt_i,
  input  logic [2:0]       ratio_i,
  output logic [DIV_W-1:0] div_o
);
  int unsigned mr;
  int unsigned br;
  int unsigned quot;

  always_comb begin
    mr    = master_ratio(ratio_i);
    br    = bit_ratio(mr, fmt_i);
    quot  = mr / br;
    div_o = quot[DIV_W-1:0];
  end
endmodule

// File: rtl/bclk_int_div.sv
module bclk_int_div #(
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fr_edge,
  input  logic [DIV_W-1:0] div_n,
  output logic             lvl_nxt,
  output logic             rise_nxt
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_nxt;
  logic [DIV_W-1:0] half;
  logic [DIV_W-1:0] last;

  always_comb begin
    half = div_n >> 1;
    last = div_n - 1'b1;
    if (fr_edge || cnt_q >= last) cnt_nxt = '0;
    else                          cnt_nxt = cnt_q + 1'b1;
    lvl_nxt  = (cnt_nxt >= half);
    rise_nxt = (cnt_nxt == half);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/bclk_ext_detect.sv
module bclk_ext_detect #(
  parameter int EDGE_THRESH    = 16,
  parameter int SILENT_PERIODS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fr_edge,
  input  logic lr_rise,
  input  logic ext_rise,
  output logic ext_mode
);
  localparam int ECNT_W = $clog2(EDGE_THRESH + 1);
  localparam int SIL_LIM_I = SILENT_PERIODS + 1;
  localparam int SIL_W = $clog2(SIL_LIM_I + 1);
  localparam logic [ECNT_W-1:0] THR = ECNT_W'(EDGE_THRESH);
  localparam logic [SIL_W-1:0]  SIL_LIM = SIL_W'(SIL_LIM_I);

  logic [ECNT_W-1:0] ecnt_q, ecnt_nxt;
  logic [SIL_W-1:0]  sil_q, sil_nxt;

  always_comb begin
    if (fr_edge)                      ecnt_nxt = ext_rise ? ECNT_W'(1) : '0;
    else if (ext_rise && ecnt_q != THR) ecnt_nxt = ecnt_q + 1'b1;
    else                              ecnt_nxt = ecnt_q;

    if (ext_rise)                        sil_nxt = '0;
    else if (lr_rise && sil_q != SIL_LIM) sil_nxt = sil_q + 1'b1;
    else                                 sil_nxt = sil_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ecnt_q   <= '0;
      sil_q    <= '0;
      ext_mode <= 1'b0;
    end else begin
      ecnt_q <= ecnt_nxt;
      sil_q  <= sil_nxt;
      if (ext_rise && ecnt_nxt == THR)        ext_mode <= 1'b1;
      else if (ext_mode && sil_nxt == SIL_LIM) ext_mode <= 1'b0;
    end
  end
endmodule

// File: rtl/bitclk_autosel.sv
module bitclk_autosel #(
  parameter int DIV_W          = 5,
  parameter int EDGE_THRESH    = 16,
  parameter int SILENT_PERIODS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lrck_i,
  input  logic             sclk_ext_i,
  input  logic [1:0]       fmt_i,
  input  logic [2:0]       ratio_i,
  output logic             bclk_o,
  output logic             bclk_rise_o,
  output logic             ext_mode_o,
  output logic [DIV_W-1:0] div_o
);
  logic lr_q, sc_q;
  logic fr_edge, lr_rise, ext_rise;
  logic lvl_nxt, rise_nxt;

  assign fr_edge  = lrck_i ^ lr_q;
  assign lr_rise  = lrck_i & ~lr_q;
  assign ext_rise = sclk_ext_i & ~sc_q;

  bclk_ratio_sel #(.DIV_W(DIV_W)) u_sel (
    .fmt_i   (fmt_i),
    .ratio_i (ratio_i),
    .div_o   (div_o)
  );

  bclk_int_div #(.DIV_W(DIV_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .fr_edge  (fr_edge),
    .div_n    (div_o),
    .lvl_nxt  (lvl_nxt),
    .rise_nxt (rise_nxt)
  );

  bclk_ext_detect #(
    .EDGE_THRESH    (EDGE_THRESH),
    .SILENT_PERIODS (SILENT_PERIODS)
  ) u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .fr_edge  (fr_edge),
    .lr_rise  (lr_rise),
    .ext_rise (ext_rise),
    .ext_mode (ext_mode_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lr_q        <= 1'b0;
      sc_q        <= 1'b0;
      bclk_o      <= 1'b0;
      bclk_rise_o <= 1'b0;
    end else begin
      lr_q <= lrck_i;
      sc_q <= sclk_ext_i;
      if (ext_mode_o) begin
        bclk_o      <= sclk_ext_i;
        bclk_rise_o <= ext_rise;
      end else begin
        bclk_o      <= lvl_nxt;
        bclk_rise_o <= rise_nxt;
      end
    end
  end
endmodule

// File: rtl/bitclk_autosel_chk.sv
module bitclk_autosel_chk #(
  parameter int DIV_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bclk_o,
  input logic             bclk_rise_o,
  input logic             ext_mode_o,
  input logic [DIV_W-1:0] div_o,
  input logic             fr_edge,
  input logic             lr_rise,
  input logic             ext_rise
);
  p_rise_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_rise_o |-> bclk_o);

  p_resync_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_edge && !ext_mode_o) |=> (!bclk_o && !bclk_rise_o));

  p_div_pow2_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(div_o) == 1) && (div_o >= 2) && (div_o <= 16));

  p_enter_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_mode_o) |-> $past(ext_rise));

  p_exit_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ext_mode_o) |-> ($past(lr_rise) && !$past(ext_rise)));

  p_ext_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ext_mode_o) |-> (bclk_rise_o == $past(ext_rise)));
endmodule

bind bitclk_autosel bitclk_autosel_chk #(.DIV_W(DIV_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bclk_o      (bclk_o),
  .bclk_rise_o (bclk_rise_o),
  .ext_mode_o  (ext_mode_o),
  .div_o       (div_o),
  .fr_edge     (fr_edge),
  .lr_rise     (lr_rise),
  .ext_rise    (ext_rise)
);

// File: tb/bitclk_autosel_tb_top.sv
`timescale 1ns/1ps
module bitclk_autosel_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lrck = 1'b0;
  logic       sclk = 1'b0;
  logic [1:0] fmt = 2'd0;
  logic [2:0] ratio = 3'd2;
  logic       bclk_o, bclk_rise_o, ext_mode_o;
  logic [4:0] div_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  string cur_req = "R9";
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  // stimulus generator controls
  int half_per = 128;
  int sc_mode = 0;   // 0 idle low, 1 free running, 2 burst after frame edge
  int sp = 6;
  int burst_n = 0;

  always #4 clk = ~clk;

  bitclk_autosel dut_i (
    .clk(clk), .rst_n(rst_n), .lrck_i(lrck), .sclk_ext_i(sclk),
    .fmt_i(fmt), .ratio_i(ratio), .bclk_o(bclk_o), .bclk_rise_o(bclk_rise_o),
    .ext_mode_o(ext_mode_o), .div_o(div_o)
  );

  function automatic int exp_div(input int code, input int f);
    int mr, br;
    case (code)
      0: mr = 128;
      1: mr = 192;
      3: mr = 384;
      4: mr = 512;
      default: mr = 256;
    endcase
    if (mr == 192 || mr == 384) br = 48;
    else if (f == 0 || f == 3) br = 32;
    else br = 64;
    return mr / br;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // stimulus: frame clock and external bit clock, driven on the falling edge
  initial begin
    int lr_cnt = 0;
    int sc_ph = 0;
    int left = 0;
    forever begin
      @(negedge clk);
      lr_cnt++;
      if (lr_cnt >= half_per) begin
        lr_cnt = 0;
        lrck = ~lrck;
        left = burst_n;
        sc_ph = 0;
      end
      if (sc_mode == 1) begin
        sc_ph = (sc_ph + 1) % sp;
        sclk = (sc_ph >= sp / 2);
      end else if (sc_mode == 2 && left > 0) begin
        sc_ph = (sc_ph + 1) % sp;
        if (!sclk && sc_ph >= sp / 2) begin
          sclk = 1'b1;
          left--;
        end else if (sc_ph < sp / 2) sclk = 1'b0;
      end else begin
        sclk = 1'b0;
      end
    end
  end

  // behavioural reference and per-cycle comparison
  int m_lr = 0, m_sc = 0, m_cnt = 0, m_ecnt = 0, m_sil = 0, m_ext = 0;
  int e_bclk = 0, e_rise = 0;
  int acc = 0, last_rises = 0, prev_lr = 0;

  always @(posedge clk) begin
    int n, cn, ec, sl;
    bit fe, lrr, er;
    cycles++;
    if (!rst_n) begin
      m_lr = 0; m_sc = 0; m_cnt = 0; m_ecnt = 0; m_sil = 0; m_ext = 0;
      e_bclk = 0; e_rise = 0;
    end else begin
      n   = exp_div(int'(ratio), int'(fmt));
      fe  = (int'(lrck) != m_lr);
      lrr = lrck && (m_lr == 0);
      er  = sclk && (m_sc == 0);
      cn  = (fe || m_cnt >= n - 1) ? 0 : m_cnt + 1;
      if (m_ext != 0) begin
        e_bclk = int'(sclk); e_rise = int'(er);
      end else begin
        e_bclk = (cn >= n / 2) ? 1 : 0; e_rise = (cn == n / 2) ? 1 : 0;
      end
      if (fe) ec = er ? 1 : 0;
      else if (er && m_ecnt < 16) ec = m_ecnt + 1;
      else ec = m_ecnt;
      if (er) sl = 0;
      else if (lrr && m_sil < 3) sl = m_sil + 1;
      else sl = m_sil;
      if (er && ec == 16) m_ext = 1;
      else if (m_ext != 0 && sl == 3) m_ext = 0;
      m_ecnt = ec; m_sil = sl; m_cnt = cn;
      m_lr = int'(lrck); m_sc = int'(sclk);
    end
    #2;
    if (cmp_en && rst_n) begin
      check(int'(bclk_o) == e_bclk, {cur_req, " bclk_o"}, int'(bclk_o), e_bclk);
      check(int'(bclk_rise_o) == e_rise, {cur_req, " bclk_rise_o"}, int'(bclk_rise_o), e_rise);
      check(int'(ext_mode_o) == m_ext, {cur_req, " ext_mode_o"}, int'(ext_mode_o), m_ext);
    end
    if (lrck && prev_lr == 0) begin
      last_rises = acc; acc = 0;
    end
    prev_lr = int'(lrck);
    acc += int'(bclk_rise_o);
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // watchdog
  initial begin
    wait (cycles > 150000 || done);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R9 reset state
    repeat (5) @(posedge clk);
    #2;
    check(bclk_o == 0 && bclk_rise_o == 0, "R9 clocks low in reset", int'(bclk_o), 0);
    check(ext_mode_o == 0, "R9 internal mode in reset", int'(ext_mode_o), 0);
    @(negedge clk); rst_n = 1'b1;
    wait_cyc(1);
    check(ext_mode_o == 0, "R9 internal after reset", int'(ext_mode_o), 0);
    cmp_en = 1'b1;

    // R3/R4 divide table sweep over every code
    cur_req = "R3";
    for (int r = 0; r < 8; r++) begin
      for (int f = 0; f < 4; f++) begin
        @(negedge clk); ratio = 3'(r); fmt = 2'(f);
        #1;
        check(int'(div_o) == exp_div(r, f), "R4 div_o table", int'(div_o), exp_div(r, f));
      end
    end

    // R1 internal clock, 256 ratio, I2S: 32 rises per frame
    @(negedge clk); ratio = 3'd2; fmt = 2'd0; half_per = 128;
    cur_req = "R1";
    wait_cyc(1200);
    check(last_rises == 32, "R1 rises per frame fmt0", last_rises, 32);
    @(negedge clk); fmt = 2'd1;
    wait_cyc(1200);
    check(last_rises == 64, "R1 rises per frame fmt1", last_rises, 64);
    @(negedge clk); ratio = 3'd3; fmt = 2'd0; half_per = 192;
    wait_cyc(1600);
    check(last_rises == 48, "R1 rises per frame ratio 384", last_rises, 48);

    // R2 resync with a half period not a multiple of the divider
    @(negedge clk); ratio = 3'd2; fmt = 2'd0; half_per = 100;
    cur_req = "R2";
    wait_cyc(900);
    @(lrck);
    wait_cyc(2);
    check(bclk_o == 0 && bclk_rise_o == 0, "R2 low after frame edge", int'(bclk_o), 0);
    @(lrck);
    wait_cyc(4);
    check(bclk_o == 0, "R2 low through first half", int'(bclk_o), 0);
    @(negedge clk); half_per = 128;

    // R6 exactly 15 edges per phase never switches
    cur_req = "R6";
    @(negedge clk); sp = 4; burst_n = 15; sc_mode = 2;
    wait_cyc(1500);
    check(ext_mode_o == 0, "R6 15 edges keep internal", int'(ext_mode_o), 0);

    // R5 exactly 16 edges per phase switches
    cur_req = "R5";
    @(negedge clk); burst_n = 16;
    wait_cyc(600);
    check(ext_mode_o == 1, "R5 16 edges select external", int'(ext_mode_o), 1);

    // R8 free running external clock
    cur_req = "R8";
    @(negedge clk); sp = 6; sc_mode = 1;
    wait_cyc(800);
    check(ext_mode_o == 1, "R8 stays external", int'(ext_mode_o), 1);
    @(posedge sclk);
    wait_cyc(2);
    check(bclk_o == 1, "R8 bclk follows external", int'(bclk_o), 1);

    // R7 silence for two whole frame periods
    cur_req = "R7";
    @(negedge clk); sc_mode = 0;
    @(posedge lrck);
    @(posedge lrck);
    wait_cyc(20);
    check(ext_mode_o == 1, "R7 no exit after one silent period", int'(ext_mode_o), 1);
    @(posedge lrck);
    wait_cyc(2);
    check(ext_mode_o == 0, "R7 exit after two silent periods", int'(ext_mode_o), 0);
    cur_req = "R1";
    wait_cyc(600);
    check(last_rises == 32, "R1 internal clock resumes", last_rises, 32);

    // R9 reset mid-run
    @(negedge clk); sc_mode = 1;
    wait_cyc(600);
    @(negedge clk); rst_n = 1'b0; cmp_en = 1'b0;
    wait_cyc(2);
    check(ext_mode_o == 0 && bclk_o == 0, "R9 reset clears external", int'(ext_mode_o), 0);
    @(negedge clk); sc_mode = 0; rst_n = 1'b1;
    wait_cyc(2);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule